// File: doc/BRIEF.md
# Variable-Length Instruction Word Assembler

This block sits between a memory of 16-bit words and an instruction decoder. It walks a 32-bit word-addressed program pointer through memory, fetching one word per accepted response, and gathers each instruction as a whole before handing it on. An instruction is one opcode word, optionally followed by a displacement word and then zero, one or two immediate words. The block decodes just enough of the opcode to know how many words follow, and it presents the opcode, a 32-bit immediate, the displacement, the index kind and an illegal flag together with a one-cycle valid strobe.

The two top opcode bits select an index variant (none, first index, second index). The length rules look only at the fourteen bits below them. The memory side is a level request: the address stays put until a response arrives in the same cycle. This lets wait states of any length stall assembly without dropping a word. A redirect reloads the pointer and discards any instruction still being gathered.

Top module: `instr_word_assembler`

## Requirements
- R1: While `rst` is high, `out_valid` and `mem_req` are 0, and `mem_addr` equals the `RESET_PP` parameter (default 0).
- R2: Each word accepted (a cycle with `mem_req` and `mem_rvalid` high and no redirect) raises `mem_addr` by exactly one on the next cycle. With no wait states, words are accepted one per cycle.
- R3: An opcode that takes no extension words produces `out_valid` in the cycle after it is accepted, with `out_imm` and `out_disp` both zero. This covers no-operand opcodes, register-to-register forms and register forms of jump/call/return.
- R4: When bits 13:8 are 0x01 and bits 7:4 are 0 or 1 (memory load/store at a literal address), two words follow. `out_imm` is {second word, first word}.
- R5: When bits 13:8 are 0x01 and bits 7:4 are 2 (load immediate), bit 3 decides the length. If bit 3 is 0, one word follows and `out_imm` = {16'h0, word}. If bit 3 is 1, two words follow, with the low half first.
- R6: When bits 13:12 are 2'b10 and bit 9 is 0 (jump/call with a literal), bit 10 decides the length. Bit 10 = 0 (relative or decrement-and-jump) means one word, zero-extended into `out_imm`. Bit 10 = 1 (absolute or call) means two words. The condition field in bits 7:4 does not change this.
- R7: `out_idx` equals opcode bits 15:14 (00 none, 01 first index, 10 second index). The length rules apply to bits 13:0 unchanged.
- R8: For index 01 or 10, a displacement word is fetched before any immediate words and appears on `out_disp`. This happens when operand field bits 3:0 equal 4'b0110, or when bits 7:4 equal 4'b0110 in a two-operand group (bits 13:8 from 0x02 to 0x13).
- R9: Opcode bits 15:14 = 11 set `out_illegal` and make a one-word instruction with zero immediate and displacement, whatever the lower bits ask for.
- R10: A redirect loads `redirect_pp` into `mem_addr` on the next cycle. It drops any partly gathered instruction and any word answered in the redirect cycle, and `out_valid` is 0 in the following cycle.
- R11: Any number of wait states between responses leaves `mem_addr` unchanged and produces the same assembled instructions as a memory with no wait states.
- R12: `out_valid` is high for exactly one cycle per instruction. Back-to-back one-word instructions with no wait states give `out_valid` on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redirect | input | 1 | Load a new program pointer and flush |
| redirect_pp | input | 32 | New program pointer |
| mem_req | output | 1 | Word request, held until answered |
| mem_addr | output | 32 | Word address (the program pointer) |
| mem_rvalid | input | 1 | Response for `mem_addr` present this cycle |
| mem_rdata | input | 16 | Returned word |
| out_valid | output | 1 | Assembled instruction strobe |
| out_op | output | 16 | Opcode word |
| out_imm | output | 32 | Immediate, low word first in memory |
| out_disp | output | 16 | Index displacement word |
| out_idx | output | 2 | Index kind from opcode bits 15:14 |
| out_illegal | output | 1 | Opcode bits 15:14 were 11 |

## Verification
Several properties are checked on every cycle: the pointer holds during wait states and steps by one per accepted word, a redirect lands on the new pointer with no strobe, every strobe follows an accepted word, and illegal instructions carry no operands. Only the bench scenarios can show that each opcode class draws the right number of words and places them in the right fields. The same applies to how the displacement is ordered ahead of the immediate, to identical results with and without wait states, and to a redirect mid-instruction resuming cleanly at the target.

// File: rtl/ifa_pkg.sv
package ifa_pkg;

  typedef enum logic [1:0] {
    IDX_NONE = 2'b00,
    IDX_X    = 2'b01,
    IDX_Y    = 2'b10,
    IDX_ILL  = 2'b11
  } idx_e;

  typedef enum logic {
    ST_OPCODE = 1'b0,
    ST_EXTEND = 1'b1
  } seq_st_e;

  // What the opcode word says about the words that follow it.
  typedef struct packed {
    logic [1:0] ext_words;
    logic       disp;
    logic       illegal;
    idx_e       idx;
  } len_info_t;

endpackage

// File: rtl/ifa_len_dec.sv
module ifa_len_dec
  import ifa_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] op,
  output len_info_t         info
);

  localparam int TOP = WORD_W - 1;

  logic [5:0] grp;
  logic [3:0] sub;
  logic [3:0] fld;
  logic       two_op;
  logic       indexed;

  assign grp = op[13:8];
  assign sub = op[7:4];
  assign fld = op[3:0];

  always_comb begin
    info.idx       = idx_e'(op[TOP -: 2]);
    info.illegal   = (info.idx == IDX_ILL);
    info.ext_words = 2'd0;
    if (grp == 6'h01) begin
      if (sub == 4'h0 || sub == 4'h1) begin
        info.ext_words = 2'd2;
      end else if (sub == 4'h2) begin
        info.ext_words = fld[3] ? 2'd2 : 2'd1;
      end
    end else if (grp[5:4] == 2'b10 && !grp[1]) begin
      info.ext_words = grp[2] ? 2'd2 : 2'd1;
    end
    two_op    = (grp >= 6'h02) && (grp <= 6'h13);
    indexed   = (info.idx == IDX_X) || (info.idx == IDX_Y);
    info.disp = indexed && ((fld == 4'b0110) || (two_op && sub == 4'b0110));
    if (info.illegal) begin
      info.ext_words = 2'd0;
      info.disp      = 1'b0;
    end
  end

endmodule

// File: rtl/ifa_seq.sv
module ifa_seq
  import ifa_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          WORD_W   = 16,
  parameter logic [31:0] RESET_PP = 32'h0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                redirect,
  input  logic [ADDR_W-1:0]   redirect_pp,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_rvalid,
  input  logic [WORD_W-1:0]   mem_rdata,
  input  len_info_t           info,
  output logic                out_valid,
  output logic [WORD_W-1:0]   out_op,
  output logic [2*WORD_W-1:0] out_imm,
  output logic [WORD_W-1:0]   out_disp,
  output logic [1:0]          out_idx,
  output logic                out_illegal
);

  localparam int IMM_W = 2 * WORD_W;

  seq_st_e           st;
  logic [ADDR_W-1:0] pp;
  logic              req_r;
  logic [WORD_W-1:0] op_r;
  logic [1:0]        idx_r;
  logic              ill_r;
  logic              disp_pend;
  logic [1:0]        ext_left;
  logic              ext_pos;
  logic [IMM_W-1:0]  imm_r;
  logic [WORD_W-1:0] disp_r;
  logic              take;
  logic [IMM_W-1:0]  imm_nxt;

  assign mem_req  = req_r;
  assign mem_addr = pp;
  assign take     = req_r && mem_rvalid && !redirect;
  assign imm_nxt  = ext_pos ? {mem_rdata, imm_r[WORD_W-1:0]}
                            : {{WORD_W{1'b0}}, mem_rdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_OPCODE;
      pp          <= ADDR_W'(RESET_PP);
      req_r       <= 1'b0;
      op_r        <= '0;
      idx_r       <= '0;
      ill_r       <= 1'b0;
      disp_pend   <= 1'b0;
      ext_left    <= '0;
      ext_pos     <= 1'b0;
      imm_r       <= '0;
      disp_r      <= '0;
      out_valid   <= 1'b0;
      out_op      <= '0;
      out_imm     <= '0;
      out_disp    <= '0;
      out_idx     <= '0;
      out_illegal <= 1'b0;
    end else begin
      req_r     <= 1'b1;
      out_valid <= 1'b0;
      if (redirect) begin
        pp        <= redirect_pp;
        st        <= ST_OPCODE;
        disp_pend <= 1'b0;
        ext_left  <= '0;
      end else if (take) begin
        pp <= pp + ADDR_W'(1);
        if (st == ST_OPCODE) begin
          if (info.ext_words == 2'd0 && !info.disp) begin
            out_valid   <= 1'b1;
            out_op      <= mem_rdata;
            out_imm     <= '0;
            out_disp    <= '0;
            out_idx     <= info.idx;
            out_illegal <= info.illegal;
          end else begin
            op_r      <= mem_rdata;
            idx_r     <= info.idx;
            ill_r     <= info.illegal;
            disp_pend <= info.disp;
            ext_left  <= info.ext_words;
            ext_pos   <= 1'b0;
            imm_r     <= '0;
            disp_r    <= '0;
            st        <= ST_EXTEND;
          end
        end else if (disp_pend) begin
          disp_r    <= mem_rdata;
          disp_pend <= 1'b0;
          if (ext_left == 2'd0) begin
            out_valid   <= 1'b1;
            out_op      <= op_r;
            out_imm     <= imm_r;
            out_disp    <= mem_rdata;
            out_idx     <= idx_r;
            out_illegal <= ill_r;
            st          <= ST_OPCODE;
          end
        end else begin
          imm_r    <= imm_nxt;
          ext_left <= ext_left - 2'd1;
          ext_pos  <= 1'b1;
          if (ext_left == 2'd1) begin
            out_valid   <= 1'b1;
            out_op      <= op_r;
            out_imm     <= imm_nxt;
            out_disp    <= disp_r;
            out_idx     <= idx_r;
            out_illegal <= ill_r;
            st          <= ST_OPCODE;
          end
        end
      end
    end
  end

  // R1: reset holds the fetch quiet at the reset pointer
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && !mem_req && mem_addr == ADDR_W'(RESET_PP)));

  // R2: an accepted word steps the pointer by one
  p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_rvalid && !redirect) |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  // R11: a wait state leaves the address alone
  p_hold_wait_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid && !redirect) |=> $stable(mem_addr));

  // R10: redirect lands on the new pointer with no strobe
  p_redirect_land_r10: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (mem_addr == $past(redirect_pp) && !out_valid));

  // R12: every strobe follows an accepted word
  p_strobe_has_word_r12: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(mem_req && mem_rvalid && !redirect));

  // R9: illegal instructions carry no operands
  p_illegal_bare_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_imm == '0 && out_disp == '0));

endmodule

// File: rtl/instr_word_assembler.sv
module instr_word_assembler
  import ifa_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          WORD_W   = 16,
  parameter logic [31:0] RESET_PP = 32'h0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                redirect,
  input  logic [ADDR_W-1:0]   redirect_pp,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_rvalid,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic                out_valid,
  output logic [WORD_W-1:0]   out_op,
  output logic [2*WORD_W-1:0] out_imm,
  output logic [WORD_W-1:0]   out_disp,
  output logic [1:0]          out_idx,
  output logic                out_illegal
);

  len_info_t info;

  ifa_len_dec #(.WORD_W(WORD_W)) u_dec (
    .op   (mem_rdata),
    .info (info)
  );

  ifa_seq #(
    .ADDR_W   (ADDR_W),
    .WORD_W   (WORD_W),
    .RESET_PP (RESET_PP)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .redirect    (redirect),
    .redirect_pp (redirect_pp),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_rvalid  (mem_rvalid),
    .mem_rdata   (mem_rdata),
    .info        (info),
    .out_valid   (out_valid),
    .out_op      (out_op),
    .out_imm     (out_imm),
    .out_disp    (out_disp),
    .out_idx     (out_idx),
    .out_illegal (out_illegal)
  );

endmodule

// File: tb/sim_instr_word_assembler.sv
module sim_instr_word_assembler;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        redirect = 1'b0;
  logic [31:0] redirect_pp = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        out_valid;
  logic [15:0] out_op;
  logic [31:0] out_imm;
  logic [15:0] out_disp;
  logic [1:0]  out_idx;
  logic        out_illegal;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int wait_cfg = 0;
  bit done = 0;
  logic [15:0] mem [64];
  int got_at [17];

  instr_word_assembler u0 (
    .clk(clk), .rst(rst), .redirect(redirect), .redirect_pp(redirect_pp),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_op(out_op),
    .out_imm(out_imm), .out_disp(out_disp), .out_idx(out_idx),
    .out_illegal(out_illegal)
  );

  always #5 clk = ~clk;

  // {op, imm, disp, idx, illegal}
  localparam logic [66:0] VEC [17] = '{
    {16'h0000, 32'h0000_0000, 16'h0000, 2'd0, 1'b0},
    {16'h0104, 32'h1234_5678, 16'h0000, 2'd0, 1'b0},
    {16'h0123, 32'h0000_BEEF, 16'h0000, 2'd0, 1'b0},
    {16'h0128, 32'hA001_0002, 16'h0000, 2'd0, 1'b0},
    {16'h0210, 32'h0000_0000, 16'h0000, 2'd0, 1'b0},
    {16'h2000, 32'h0000_FFFE, 16'h0000, 2'd0, 1'b0},
    {16'h2110, 32'h0000_0010, 16'h0000, 2'd0, 1'b0},
    {16'h2500, 32'h0000_0100, 16'h0000, 2'd0, 1'b0},
    {16'h2C00, 32'h0001_4000, 16'h0000, 2'd0, 1'b0},
    {16'h2208, 32'h0000_0000, 16'h0000, 2'd0, 1'b0},
    {16'h2800, 32'h0000_0003, 16'h0000, 2'd0, 1'b0},
    {16'h4126, 32'h0000_0055, 16'h0007, 2'd1, 1'b0},
    {16'h8467, 32'h0000_0000, 16'hFFF0, 2'd2, 1'b0},
    {16'hC128, 32'h0000_0000, 16'h0000, 2'd3, 1'b1},
    {16'h4105, 32'h2222_1111, 16'h0000, 2'd1, 1'b0},
    {16'h3000, 32'h0000_0000, 16'h0000, 2'd0, 1'b0},
    {16'h0031, 32'h0000_0000, 16'h0000, 2'd0, 1'b0}
  };

  function automatic string tag_of(int i);
    case (i)
      1:        return "R4";
      2, 3:     return "R5";
      5, 6, 7, 8, 10: return "R6";
      11, 12:   return "R8";
      13:       return "R9";
      14:       return "R7";
      16:       return "R12";
      default:  return "R3";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [66:0] act, input logic [66:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Memory responder: answers the held request after wait_cfg idle cycles.
  initial begin
    int wcnt;
    wcnt = 0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        if (wcnt >= wait_cfg) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem[mem_addr[5:0]];
          wcnt = 0;
        end else begin
          mem_rvalid = 1'b0;
          wcnt++;
        end
      end else begin
        mem_rvalid = 1'b0;
        wcnt = 0;
      end
    end
  end

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic next_out(output bit ok);
    ok = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (out_valid) begin
        ok = 1;
        return;
      end
    end
  endtask

  task automatic expect_vec(input int i, input string tag);
    bit ok;
    next_out(ok);
    got_at[i] = cyc;
    check(ok, tag, $sformatf("vector %0d strobe", i), {66'd0, ok}, 67'd1);
    if (ok)
      check({out_op, out_imm, out_disp, out_idx, out_illegal} == VEC[i], tag,
            $sformatf("vector %0d fields", i),
            {out_op, out_imm, out_disp, out_idx, out_illegal}, VEC[i]);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 64; a++) mem[a] = 16'h0000;
    mem[1]  = 16'h0104; mem[2]  = 16'h5678; mem[3]  = 16'h1234;
    mem[4]  = 16'h0123; mem[5]  = 16'hBEEF;
    mem[6]  = 16'h0128; mem[7]  = 16'h0002; mem[8]  = 16'hA001;
    mem[9]  = 16'h0210;
    mem[10] = 16'h2000; mem[11] = 16'hFFFE;
    mem[12] = 16'h2110; mem[13] = 16'h0010;
    mem[14] = 16'h2500; mem[15] = 16'h0100; mem[16] = 16'h0000;
    mem[17] = 16'h2C00; mem[18] = 16'h4000; mem[19] = 16'h0001;
    mem[20] = 16'h2208;
    mem[21] = 16'h2800; mem[22] = 16'h0003;
    mem[23] = 16'h4126; mem[24] = 16'h0007; mem[25] = 16'h0055;
    mem[26] = 16'h8467; mem[27] = 16'hFFF0;
    mem[28] = 16'hC128;
    mem[29] = 16'h4105; mem[30] = 16'h1111; mem[31] = 16'h2222;
    mem[32] = 16'h3000;
    mem[33] = 16'h0031;

    // R1: reset state
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(!out_valid && !mem_req && mem_addr == 32'h0, "R1", "reset outputs",
          {34'd0, out_valid, mem_req, mem_addr}, 67'd0);

    // Table walk, no wait states
    wait_cfg = 0;
    do_reset();
    for (int i = 0; i < 17; i++) expect_vec(i, tag_of(i));
    check(got_at[1] - got_at[0] == 3, "R2", "one word per cycle",
          67'(got_at[1] - got_at[0]), 67'd3);
    check(got_at[16] - got_at[15] == 1, "R12", "back-to-back strobes",
          67'(got_at[16] - got_at[15]), 67'd1);

    // Same table with wait states
    wait_cfg = 3;
    do_reset();
    for (int i = 0; i < 17; i++) expect_vec(i, "R11");

    // R10: redirect in the middle of a three-word instruction
    wait_cfg = 0;
    do_reset();
    for (int k = 0; k < 50 && mem_addr != 32'd2; k++) @(negedge clk);
    redirect = 1'b1;
    redirect_pp = 32'd28;
    @(negedge clk);
    redirect = 1'b0;
    check(mem_addr == 32'd28 && !out_valid, "R10", "redirect landing",
          {34'd0, out_valid, mem_addr}, {35'd0, 32'd28});
    expect_vec(13, "R10");
    expect_vec(14, "R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule